// File: doc/BRIEF.md
# Two-Channel Deferred DAC Update Controller

This block sits between a host write port and two digital-to-analog converter code latches. Each host write is one 16-bit word that carries both the target channel and the 12-bit code. The word is held in a single pending slot, and a busy flag is raised. The pending value is copied into the addressed output latch either on the next clock or when a chosen hardware event occurs.

A 2-bit update-source select picks one of four sources: immediate transfer, a timer-overflow pulse, an external update pulse, or a pacer tick. The host polls the busy flag and waits until it is low before it writes again. Writes that arrive while busy is high, and writes that address a channel the block does not have, are dropped.

Top module: `dac_update_ctrl`

## Requirements
- R1: Synchronous active-high reset sets both output codes to mid-scale 0x800 and clears busy, and this also cancels a pending value.
- R2: The write word puts the channel number in bits 15:12 and the code in bits 11:0. Channel 0 drives `dac0_code` and channel 1 drives `dac1_code`.
- R3: A write that is accepted (wr_en high, busy low, channel 0 or 1) sets busy on the clock edge that captures it.
- R4: With update source 0 (immediate), the pending code reaches its output one clock after the capturing edge, and busy falls on that same edge.
- R5: With update source 1 (timer overflow), 2 (external pulse) or 3 (pacer tick), the value stays pending with busy high until an edge at which the selected pulse is high. The output then updates and busy falls on that edge.
- R6: Pulses on the two event inputs that are not selected have no effect. A selected pulse in the same cycle as the capturing write does not release the value.
- R7: A write to a channel number from 2 to 15 changes no output and leaves busy low.
- R8: A write that arrives while busy is high is dropped, and the first pending value is kept.
- R9: An output changes only when a transfer addresses it. The other channel keeps its code.
- R10: The update source is read at transfer time. Switching to source 0 while a value is pending releases it on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe, one cycle per word |
| wr_data | input | 16 | Channel number in 15:12, code in 11:0 |
| upd_src | input | 2 | Update source: 0 immediate, 1 timer, 2 external, 3 pacer |
| tmr_ovf | input | 1 | Timer-overflow pulse |
| ext_upd | input | 1 | External update pulse |
| pacer_tick | input | 1 | Pacer tick pulse |
| dac0_code | output | 12 | Code latched for channel 0 |
| dac1_code | output | 12 | Code latched for channel 1 |
| buf_busy | output | 1 | High while a value is pending |

## Verification
The bench builds the block with the default widths: a 4-bit channel field, a 12-bit code and two channels. Because the channel field is much wider than the channel count needs, the unused numbers 2 through 15 can be reached, and the bench uses them to probe the drop path. The 12-bit code lets the bench drive the extreme codes 0x000 and 0xFFF as well as the mid-scale reset value.

// File: rtl/dac_upd_pkg.sv
package dac_upd_pkg;

    localparam int CODE_W   = 12;
    localparam int CHAN_W   = 4;
    localparam int WORD_W   = CODE_W + CHAN_W;
    localparam int NUM_CH   = 2;
    localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

    typedef enum logic [1:0] {
        SRC_IMMEDIATE = 2'd0,
        SRC_TIMER     = 2'd1,
        SRC_EXTERNAL  = 2'd2,
        SRC_PACER     = 2'd3
    } upd_src_e;

    typedef struct packed {
        logic                valid;
        logic [CH_IDX_W-1:0] ch;
        logic [CODE_W-1:0]   code;
    } dac_req_t;

    function automatic logic chan_in_range(input logic [CHAN_W-1:0] ch);
        return ch < CHAN_W'(NUM_CH);
    endfunction

endpackage

// File: rtl/dac_wr_decode.sv
module dac_wr_decode
    import dac_upd_pkg::*;
(
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output dac_req_t          req
);
    logic [CHAN_W-1:0] ch_field;

    always_comb begin
        ch_field  = wr_data[WORD_W-1:CODE_W];
        req.valid = wr_en && chan_in_range(ch_field);
        req.ch    = ch_field[CH_IDX_W-1:0];
        req.code  = wr_data[CODE_W-1:0];
    end
endmodule

// File: rtl/dac_event_sel.sv
module dac_event_sel
    import dac_upd_pkg::*;
(
    input  logic [1:0] upd_src,
    input  logic       tmr_ovf,
    input  logic       ext_upd,
    input  logic       pacer_tick,
    output logic       fire
);
    always_comb begin
        case (upd_src_e'(upd_src))
            SRC_IMMEDIATE: fire = 1'b1;
            SRC_TIMER:     fire = tmr_ovf;
            SRC_EXTERNAL:  fire = ext_upd;
            SRC_PACER:     fire = pacer_tick;
            default:       fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/dac_pend_buf.sv
module dac_pend_buf
    import dac_upd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  dac_req_t req,
    input  logic     fire,
    output logic     busy,
    output dac_req_t xfer
);
    logic [CH_IDX_W-1:0] pend_ch;
    logic [CODE_W-1:0]   pend_code;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            pend_ch   <= '0;
            pend_code <= '0;
        end else if (busy) begin
            if (fire) busy <= 1'b0;
        end else if (req.valid) begin
            busy      <= 1'b1;
            pend_ch   <= req.ch;
            pend_code <= req.code;
        end
    end

    always_comb begin
        xfer.valid = busy && fire;
        xfer.ch    = pend_ch;
        xfer.code  = pend_code;
    end
endmodule

// File: rtl/dac_out_latch.sv
module dac_out_latch
    import dac_upd_pkg::*;
#(
    parameter int CH_ID = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  dac_req_t          xfer,
    output logic [CODE_W-1:0] code
);
    localparam logic [CH_IDX_W-1:0] MY_ID = CH_IDX_W'(CH_ID);

    always_ff @(posedge clk) begin
        if (rst)
            code <= MID_CODE;
        else if (xfer.valid && xfer.ch == MY_ID)
            code <= xfer.code;
    end
endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
    import dac_upd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [1:0]        upd_src,
    input  logic              tmr_ovf,
    input  logic              ext_upd,
    input  logic              pacer_tick,
    output logic [CODE_W-1:0] dac0_code,
    output logic [CODE_W-1:0] dac1_code,
    output logic              buf_busy
);
    dac_req_t          req;
    dac_req_t          xfer;
    logic              fire;
    logic [CODE_W-1:0] codes [NUM_CH];

    dac_wr_decode u_dec (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .req     (req)
    );

    dac_event_sel u_sel (
        .upd_src    (upd_src),
        .tmr_ovf    (tmr_ovf),
        .ext_upd    (ext_upd),
        .pacer_tick (pacer_tick),
        .fire       (fire)
    );

    dac_pend_buf u_buf (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .fire (fire),
        .busy (buf_busy),
        .xfer (xfer)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dac_out_latch #(.CH_ID(g)) u_lat (
            .clk  (clk),
            .rst  (rst),
            .xfer (xfer),
            .code (codes[g])
        );
    end

    assign dac0_code = codes[0];
    assign dac1_code = codes[1];
endmodule

// File: rtl/dac_update_chk.sv
module dac_update_chk
    import dac_upd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_data,
    input logic [1:0]        upd_src,
    input logic              tmr_ovf,
    input logic              ext_upd,
    input logic              pacer_tick,
    input logic [CODE_W-1:0] dac0_code,
    input logic [CODE_W-1:0] dac1_code,
    input logic              buf_busy
);
    logic ev_sel;
    assign ev_sel = (upd_src == 2'd1 && tmr_ovf) ||
                    (upd_src == 2'd2 && ext_upd) ||
                    (upd_src == 2'd3 && pacer_tick);

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) && !rst |-> dac0_code == MID_CODE && dac1_code == MID_CODE && !buf_busy);

    assert_accept_sets_busy_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en && !buf_busy && wr_data[WORD_W-1:CODE_W] < CHAN_W'(NUM_CH) |=> buf_busy);

    assert_immediate_release_R4: assert property (@(posedge clk) disable iff (rst)
        buf_busy && upd_src == 2'd0 |=> !buf_busy);

    assert_deferred_hold_R5: assert property (@(posedge clk) disable iff (rst)
        buf_busy && upd_src != 2'd0 && !ev_sel |=> buf_busy);

    assert_bad_chan_idle_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en && !buf_busy && wr_data[WORD_W-1:CODE_W] >= CHAN_W'(NUM_CH) |=> !buf_busy);

    assert_idle_out0_stable_R9: assert property (@(posedge clk) disable iff (rst)
        !buf_busy |=> $stable(dac0_code));

    assert_idle_out1_stable_R9: assert property (@(posedge clk) disable iff (rst)
        !buf_busy |=> $stable(dac1_code));
endmodule

bind dac_update_ctrl dac_update_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .upd_src    (upd_src),
    .tmr_ovf    (tmr_ovf),
    .ext_upd    (ext_upd),
    .pacer_tick (pacer_tick),
    .dac0_code  (dac0_code),
    .dac1_code  (dac1_code),
    .buf_busy   (buf_busy)
);

// File: tb/tb_dac_update_ctrl.sv
module tb_dac_update_ctrl;

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] word;
        logic [11:0] e0;
        logic [11:0] e1;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 16'h0123, 12'h123, 12'h800},
        '{2'd0, 16'h1ABC, 12'h123, 12'hABC},
        '{2'd1, 16'h0FFF, 12'hFFF, 12'hABC},
        '{2'd2, 16'h1000, 12'hFFF, 12'h000},
        '{2'd3, 16'h0456, 12'h456, 12'h000},
        '{2'd0, 16'h2777, 12'h456, 12'h000},
        '{2'd3, 16'hF111, 12'h456, 12'h000},
        '{2'd2, 16'h1555, 12'h456, 12'h555}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [1:0]  upd_src = '0;
    logic        tmr_ovf = 1'b0;
    logic        ext_upd = 1'b0;
    logic        pacer_tick = 1'b0;
    logic [11:0] dac0_code;
    logic [11:0] dac1_code;
    logic        buf_busy;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dac_update_ctrl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .upd_src(upd_src), .tmr_ovf(tmr_ovf), .ext_upd(ext_upd),
        .pacer_tick(pacer_tick), .dac0_code(dac0_code),
        .dac1_code(dac1_code), .buf_busy(buf_busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_ev(input logic [2:0] m);
        {tmr_ovf, ext_upd, pacer_tick} = m;
    endtask

    task automatic do_write(input logic [15:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 dac0 reset", dac0_code, 12'h800);
        chk("R1 dac1 reset", dac1_code, 12'h800);
        chk("R1 busy reset", buf_busy, 0);

        for (int i = 0; i < NV; i++) begin
            logic [2:0] sel;
            logic [11:0] p0, p1;
            p0 = dac0_code;
            p1 = dac1_code;
            upd_src = VECS[i].mode;
            sel = (VECS[i].mode == 2'd0) ? 3'b000 : (3'b100 >> (VECS[i].mode - 2'd1));
            do_write(VECS[i].word);
            if (VECS[i].word[15:12] < 4'd2) begin
                chk("R3 busy after write", buf_busy, 1);
                if (VECS[i].mode == 2'd0) begin
                    @(negedge clk);
                    chk("R4 immediate busy", buf_busy, 0);
                end else begin
                    set_ev(~sel);
                    @(negedge clk);
                    set_ev(3'b000);
                    chk("R6 other events busy", buf_busy, 1);
                    chk("R6 other events dac0", dac0_code, p0);
                    chk("R6 other events dac1", dac1_code, p1);
                    set_ev(sel);
                    @(negedge clk);
                    set_ev(3'b000);
                    chk("R5 selected event busy", buf_busy, 0);
                end
                chk("R2 R9 dac0 after transfer", dac0_code, VECS[i].e0);
                chk("R2 R9 dac1 after transfer", dac1_code, VECS[i].e1);
            end else begin
                chk("R7 bad channel busy", buf_busy, 0);
                set_ev(3'b111);
                @(negedge clk);
                set_ev(3'b000);
                chk("R7 bad channel dac0", dac0_code, VECS[i].e0);
                chk("R7 bad channel dac1", dac1_code, VECS[i].e1);
            end
        end

        // R8: second write while busy is dropped
        upd_src = 2'd1;
        do_write(16'h0AAA);
        do_write(16'h1BBB);
        chk("R8 busy held", buf_busy, 1);
        set_ev(3'b100);
        @(negedge clk);
        set_ev(3'b000);
        chk("R8 first value kept", dac0_code, 12'hAAA);
        chk("R8 busy cleared", buf_busy, 0);
        set_ev(3'b100);
        @(negedge clk);
        set_ev(3'b000);
        chk("R8 dropped write absent", dac1_code, 12'h555);

        // R6: selected pulse in the write cycle does not release
        upd_src = 2'd2;
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 16'h0321;
        ext_upd = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        ext_upd = 1'b0;
        chk("R6 same-cycle busy", buf_busy, 1);
        chk("R6 same-cycle dac0", dac0_code, 12'hAAA);
        // R10: switch to immediate releases next edge
        upd_src = 2'd0;
        @(negedge clk);
        chk("R10 switch dac0", dac0_code, 12'h321);
        chk("R10 switch busy", buf_busy, 0);

        // R1: reset cancels a pending value
        upd_src = 2'd3;
        do_write(16'h1999);
        chk("R3 pending before reset", buf_busy, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mid reset dac0", dac0_code, 12'h800);
        chk("R1 mid reset dac1", dac1_code, 12'h800);
        chk("R1 mid reset busy", buf_busy, 0);
        pacer_tick = 1'b1;
        @(negedge clk);
        pacer_tick = 1'b0;
        chk("R1 pending cancelled", dac1_code, 12'h800);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule